// File: doc/BRIEF.md
# PLL Output Mode Remux Controller

This block holds the 2-bit mode code that steers a clock output mux between three sources: a crystal reference, a PLL output and a low-frequency 32 kHz clock. Software sets the code through a 32-bit write port. In that port the upper half carries a bit-enable for each bit of the lower half, so software can change one bit without a read-modify-write.

A PLL retune is bracketed by two single-cycle strobes, one before the frequency change and one after it. On the pre-change strobe, if the output is on the PLL, the block parks it on the crystal reference and records that it made the move in a remuxed flag. On the post-change strobe it puts the output back on the PLL, but only if it had made that move. The three source clocks are modelled as plain selectable inputs. This block does no glitch-free switching between clock domains.

Top module: `pll_mode_remux`

## Requirements
- R1: After reset the mode code is 0, the remuxed flag is 0, and `clk_o` follows `ref_clk_i`.
- R2: `clk_o` follows `ref_clk_i` for mode 0, `pll_clk_i` for mode 1 and `lf_clk_i` for mode 2. Mode 3 is reserved and also selects `ref_clk_i`.
- R3: A write with `wr_en_i` high and no event strobe changes mode bit k (k = 0, 1) to `wr_data_i[k]` only when `wr_data_i[16+k]` is 1. All other write bits have no effect. Code 3 can be stored and reads back as 3 on `mode_o`.
- R4: A pre-change strobe while the mode is 1 sets the mode to 0 and the flag to 1 on the next cycle.
- R5: A pre-change strobe while the mode is 0, 2 or 3 leaves both the mode and the flag unchanged.
- R6: A post-change strobe without a pre-change strobe, while the flag is 1, sets the mode to 1 and clears the flag.
- R7: A post-change strobe with the flag at 0 leaves both the mode and the flag unchanged.
- R8: When the pre-change and post-change strobes are high in the same cycle, only the pre-change action happens.
- R9: In a cycle with any event strobe high, a software write is dropped. A software write never changes the flag.
- R10: With no write and no strobe, the mode and the flag hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Mode write strobe |
| wr_data_i | input | 32 | Write word: [31:16] bit enables, [15:0] data; mode field at [1:0] |
| pre_chg_i | input | 1 | Pre-change event pulse |
| post_chg_i | input | 1 | Post-change event pulse |
| ref_clk_i | input | 1 | Crystal reference source |
| pll_clk_i | input | 1 | PLL output source |
| lf_clk_i | input | 1 | 32 kHz source |
| mode_o | output | 2 | Stored mode code |
| remuxed_o | output | 1 | Flag: output was moved off the PLL by a pre-change event |
| clk_o | output | 1 | Selected clock |

## Verification
If the mode register is wrong, `clk_o` tracks the wrong source and `mode_o` shows the wrong code one cycle after the offending edge. If the flag is wrong, the mode may still look correct until the next post-change strobe. The strobe then either fails to return the output to the PLL or pulls it there without cause, one cycle later. The sweep therefore sets up every pair of mode and flag values and applies every combination of strobe and write, so that an error in the flag reaches `mode_o` within one event.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;
  typedef enum logic [1:0] {
    MODE_SLOW = 2'd0,
    MODE_NORM = 2'd1,
    MODE_DEEP = 2'd2,
    MODE_RSVD = 2'd3
  } pll_mode_e;
  localparam int unsigned MODE_W = 2;
endpackage

// File: rtl/pll_mode_merge.sv
module pll_mode_merge
  import pll_mode_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned FIELD_LSB = 0
) (
  input  logic [MODE_W-1:0] cur_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [MODE_W-1:0] merged_o
);
  localparam int unsigned HALF = WORD_W / 2;

  for (genvar k = 0; k < MODE_W; k++) begin : g_bit
    assign merged_o[k] = word_i[HALF+FIELD_LSB+k] ? word_i[FIELD_LSB+k] : cur_i[k];
  end
endmodule

// File: rtl/pll_remux_seq.sv
module pll_remux_seq
  import pll_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [MODE_W-1:0] wr_mode_i,
  input  logic              pre_chg_i,
  input  logic              post_chg_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              remuxed_o
);
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              flag_q, flag_d;

  always_comb begin
    mode_d = mode_q;
    flag_d = flag_q;
    if (pre_chg_i) begin
      // pre-change wins over post-change and over writes
      if (mode_q == MODE_NORM) begin
        mode_d = MODE_SLOW;
        flag_d = 1'b1;
      end
    end else if (post_chg_i) begin
      if (flag_q) begin
        mode_d = MODE_NORM;
        flag_d = 1'b0;
      end
    end else if (wr_en_i) begin
      mode_d = wr_mode_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SLOW;
      flag_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      flag_q <= flag_d;
    end
  end

  assign mode_o    = mode_q;
  assign remuxed_o = flag_q;
endmodule

// File: rtl/pll_clk_sel.sv
module pll_clk_sel
  import pll_mode_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              ref_clk_i,
  input  logic              pll_clk_i,
  input  logic              lf_clk_i,
  output logic              clk_o
);
  always_comb begin
    unique case (pll_mode_e'(mode_i))
      MODE_NORM: clk_o = pll_clk_i;
      MODE_DEEP: clk_o = lf_clk_i;
      default:   clk_o = ref_clk_i;  // slow and reserved
    endcase
  end
endmodule

// File: rtl/pll_mode_remux.sv
module pll_mode_remux
  import pll_mode_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned FIELD_LSB = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              pre_chg_i,
  input  logic              post_chg_i,
  input  logic              ref_clk_i,
  input  logic              pll_clk_i,
  input  logic              lf_clk_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              remuxed_o,
  output logic              clk_o
);
  logic [MODE_W-1:0] merged;

  pll_mode_merge #(.WORD_W(WORD_W), .FIELD_LSB(FIELD_LSB)) u_merge (
    .cur_i    (mode_o),
    .word_i   (wr_data_i),
    .merged_o (merged)
  );

  pll_remux_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_mode_i  (merged),
    .pre_chg_i  (pre_chg_i),
    .post_chg_i (post_chg_i),
    .mode_o     (mode_o),
    .remuxed_o  (remuxed_o)
  );

  pll_clk_sel u_sel (
    .mode_i    (mode_o),
    .ref_clk_i (ref_clk_i),
    .pll_clk_i (pll_clk_i),
    .lf_clk_i  (lf_clk_i),
    .clk_o     (clk_o)
  );
endmodule

// File: rtl/pll_mode_remux_chk.sv
module pll_mode_remux_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       pre_chg_i,
  input logic       post_chg_i,
  input logic       ref_clk_i,
  input logic       pll_clk_i,
  input logic       lf_clk_i,
  input logic [1:0] mode_o,
  input logic       remuxed_o,
  input logic       clk_o
);
  // R2: source selection seen at the ports
  always_comb begin
    if (rst_ni) begin
      a_r2_clk_select: assert (clk_o == ((mode_o == 2'd1) ? pll_clk_i :
                                         (mode_o == 2'd2) ? lf_clk_i : ref_clk_i));
    end
  end

  a_r4_pre_parks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_chg_i && mode_o == 2'd1) |=> (mode_o == 2'd0 && remuxed_o));

  a_r5_pre_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_chg_i && mode_o != 2'd1) |=> ($stable(mode_o) && $stable(remuxed_o)));

  a_r6_post_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_chg_i && !pre_chg_i && remuxed_o) |=> (mode_o == 2'd1 && !remuxed_o));

  a_r7_post_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_chg_i && !pre_chg_i && !remuxed_o) |=> ($stable(mode_o) && !remuxed_o));

  a_r9_write_keeps_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !pre_chg_i && !post_chg_i) |=> $stable(remuxed_o));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !pre_chg_i && !post_chg_i) |=> ($stable(mode_o) && $stable(remuxed_o)));
endmodule

bind pll_mode_remux pll_mode_remux_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .pre_chg_i  (pre_chg_i),
  .post_chg_i (post_chg_i),
  .ref_clk_i  (ref_clk_i),
  .pll_clk_i  (pll_clk_i),
  .lf_clk_i   (lf_clk_i),
  .mode_o     (mode_o),
  .remuxed_o  (remuxed_o),
  .clk_o      (clk_o)
);

// File: tb/sim_pll_mode_remux.sv
`timescale 1ns/1ps
module sim_pll_mode_remux;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        pre_chg_i = 1'b0;
  logic        post_chg_i = 1'b0;
  logic        ref_clk_i = 1'b0;
  logic        pll_clk_i = 1'b0;
  logic        lf_clk_i = 1'b0;
  logic [1:0]  mode_o;
  logic        remuxed_o;
  logic        clk_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  pll_mode_remux u0 (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one cycle starting at a negedge; returns at the next negedge
  task automatic step(bit wr, logic [31:0] d, bit pre, bit post);
    wr_en_i = wr; wr_data_i = d; pre_chg_i = pre; post_chg_i = post;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0; pre_chg_i = 1'b0; post_chg_i = 1'b0;
  endtask

  function automatic logic [31:0] full_wr(int m);
    return {16'h0003, 14'h0, 2'(m)};
  endfunction

  // bring the block to a known mode/flag pair using only port behaviour
  task automatic set_state(int m, bit f);
    if (f) begin
      step(1, full_wr(1), 0, 0);
      step(0, '0, 1, 0);
    end else begin
      step(0, '0, 0, 1);
    end
    step(1, full_wr(m), 0, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    ref_clk_i = 1'b1;
    #0.5;
    // R1: reset state
    chk("R1 mode", mode_o, 0);
    chk("R1 flag", remuxed_o, 0);
    chk("R1 clk", clk_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3: masked write sweep with junk outside the field
    for (int old = 0; old < 4; old++)
      for (int msk = 0; msk < 4; msk++)
        for (int dat = 0; dat < 4; dat++) begin
          int exp;
          step(1, full_wr(old), 0, 0);
          step(1, {14'h3FFF & 14'h2A55, 2'(msk), 14'h3A5C, 2'(dat)}, 0, 0);
          exp = (old & ~msk) | (dat & msk);
          chk("R3 masked write", mode_o, exp);
        end

    // R2: source select, all modes and level patterns
    for (int m = 0; m < 4; m++) begin
      step(1, full_wr(m), 0, 0);
      for (int p = 0; p < 8; p++) begin
        int exp;
        ref_clk_i = p[0]; pll_clk_i = p[1]; lf_clk_i = p[2];
        #0.5;
        exp = (m == 1) ? p[1] : (m == 2) ? p[2] : p[0];
        chk("R2 clk select", clk_o, exp);
      end
    end

    // R4..R10: every mode/flag start, every strobe combination, write on/off
    for (int m = 0; m < 4; m++)
      for (int f = 0; f < 2; f++)
        for (int ev = 0; ev < 4; ev++)
          for (int wr = 0; wr < 2; wr++) begin
            int em, ef, w;
            bit pre, post;
            string tag;
            pre = ev[0]; post = ev[1];
            w = (m + 1) % 4;
            set_state(m, f[0]);
            chk("R9 setup flag", remuxed_o, f);
            step(wr[0], full_wr(w), pre, post);
            em = m; ef = f;
            if (pre) begin
              tag = post ? "R8 both" : (m == 1 ? "R4 park" : "R5 pre idle");
              if (m == 1) begin em = 0; ef = 1; end
            end else if (post) begin
              tag = f ? "R6 restore" : "R7 post idle";
              if (f) begin em = 1; ef = 0; end
            end else if (wr) begin
              tag = "R9 write keeps flag";
              em = w;
            end else begin
              tag = "R10 hold";
            end
            if (wr && (pre || post)) tag = {tag, " R9 write dropped"};
            chk({tag, " mode"}, mode_o, em);
            chk({tag, " flag"}, remuxed_o, ef);
          end

    // R6: full retune bracket where software moved the mode in between
    set_state(1, 0);
    step(0, '0, 1, 0);
    step(1, full_wr(2), 0, 0);
    step(0, '0, 0, 1);
    chk("R6 bracket mode", mode_o, 1);
    chk("R6 bracket flag", remuxed_o, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule